// File: doc/BRIEF.md
# Single-Level Page-Table Walker

This block resolves a translation miss without software help. When the translation cache reports a miss, the walker takes the missing virtual page number. It forms the address of the matching page-table entry from a base register owned by the running process, reads that one 32-bit word over a request/grant and response-strobe memory port, and decodes the word it gets back. A present entry is handed back as a translation for installation, together with its frame number, accessed flag and dirty flag, and the faulting access can then be retried. An absent entry produces an exception pulse for the operating system, and no translation is offered.

Entries are 4 bytes, so the entry address is the base register plus four times the page number, taken modulo 2^ADDR_W. The walker handles one miss at a time and shows this on its busy output. The base register can be rewritten at any time. A walk already in flight keeps the address it formed when it accepted its miss.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, and whenever busy is low, mem_req, xlat_valid and fault_valid are low.
- R2: When busy is low and miss_valid is high at a rising edge, the next cycle has busy and mem_req high, with mem_addr equal to base + 4 × miss_vpn (mod 2^ADDR_W). The base used is the value the register held before that edge.
- R3: mem_req stays high with an unchanged mem_addr until the cycle in which mem_gnt is high, and it is low from the following cycle onward.
- R4: mem_rsp_valid is only taken after the grant. The cycle after it is taken, exactly one of xlat_valid and fault_valid is high for exactly one cycle.
- R5: If bit 0 (valid) of the returned word is 1, xlat_valid pulses with xlat_frame = word[31:12], xlat_accessed = word[1], xlat_dirty = word[2], and walk_vpn = the page number of the miss.
- R6: If bit 0 of the returned word is 0, fault_valid pulses with walk_vpn = the page number of the miss, and xlat_valid stays low.
- R7: busy is high from the cycle after a miss is accepted through the result cycle, and low in the cycle after that. A miss_valid seen while busy is ignored: it does not change walk_vpn and it starts no walk.
- R8: Writing the base register during a walk leaves that walk's mem_addr unchanged. The next walk uses the new base.
- R9: xlat_valid and fault_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load the page-table base register |
| base_wr_data | input | ADDR_W | New base value |
| miss_valid | input | 1 | Translation miss present |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the entry being read |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Returned page-table entry |
| xlat_valid | output | 1 | One-cycle pulse: translation found |
| xlat_frame | output | 20 | Physical frame number |
| xlat_accessed | output | 1 | Accessed flag from the entry |
| xlat_dirty | output | 1 | Dirty flag from the entry |
| fault_valid | output | 1 | One-cycle pulse: entry absent, exception |
| walk_vpn | output | VPN_W | Page number of the walk that finished |

## Verification
The situation hardest to reach from the ports is a change that arrives while a walk is parked: a base-register write while the request is waiting for its grant, or a second miss raised while the walker waits for data. The bench holds off the grant for up to two cycles and the response for up to two cycles. During those windows it writes a new base and raises a second miss with a different page number. It then confirms that the request address does not move, that the result carries the original page number, that no second request follows, and that the next walk picks up the new base.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  // entry layout (fixed 32-bit word)
  localparam int PTE_W         = 32;
  localparam int PTE_PRESENT   = 0;
  localparam int PTE_ACCESSED  = 1;
  localparam int PTE_DIRTY     = 2;
  localparam int PTE_FRAME_LSB = 12;
  localparam int PTE_FRAME_W   = PTE_W - PTE_FRAME_LSB;
  localparam int PTE_SIZE_LOG2 = 2;

endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);

  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] addr_q,
  output logic [VPN_W-1:0]  vpn_q
);

  localparam int OFS_W = VPN_W + PTE_SIZE_LOG2;

  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] addr_d;
  logic [VPN_W-1:0]  vpn_d;

  always_comb begin
    ofs    = {vpn, {PTE_SIZE_LOG2{1'b0}}};
    addr_d = addr_q;
    vpn_d  = vpn_q;
    if (load) begin
      addr_d = base + ADDR_W'(ofs);
      vpn_d  = vpn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vpn_q  <= '0;
    end else begin
      addr_q <= addr_d;
      vpn_q  <= vpn_d;
    end
  end

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic mem_gnt,
  input  logic mem_rsp_valid,
  output logic load_walk,
  output logic capture_rsp,
  output logic busy,
  output logic mem_req,
  output logic done
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    load_walk   = 1'b0;
    capture_rsp = 1'b0;
    unique case (state_q)
      ST_IDLE: if (miss_valid) begin
        load_walk = 1'b1;
        state_d   = ST_REQ;
      end
      ST_REQ:  if (mem_gnt) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        capture_rsp = 1'b1;
        state_d     = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign mem_req = (state_q == ST_REQ);
  assign done    = (state_q == ST_DONE);

endmodule

// File: rtl/pgwalk_pte_decode.sv
module pgwalk_pte_decode
  import pgwalk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [PTE_W-1:0]       rsp_data,
  input  logic                   done,
  output logic                   xlat_valid,
  output logic                   fault_valid,
  output logic [PTE_FRAME_W-1:0] frame,
  output logic                   accessed,
  output logic                   dirty
);

  logic                   present_q, present_d;
  logic                   acc_q, acc_d;
  logic                   dirty_q, dirty_d;
  logic [PTE_FRAME_W-1:0] frame_q, frame_d;
  logic                   unused_rsvd;

  assign unused_rsvd = ^rsp_data[PTE_FRAME_LSB-1:PTE_DIRTY+1];

  always_comb begin
    present_d = present_q;
    acc_d     = acc_q;
    dirty_d   = dirty_q;
    frame_d   = frame_q;
    if (capture) begin
      present_d = rsp_data[PTE_PRESENT];
      acc_d     = rsp_data[PTE_ACCESSED];
      dirty_d   = rsp_data[PTE_DIRTY];
      frame_d   = rsp_data[PTE_W-1:PTE_FRAME_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      acc_q     <= 1'b0;
      dirty_q   <= 1'b0;
      frame_q   <= '0;
    end else begin
      present_q <= present_d;
      acc_q     <= acc_d;
      dirty_q   <= dirty_d;
      frame_q   <= frame_d;
    end
  end

  assign xlat_valid  = done &  present_q;
  assign fault_valid = done & ~present_q;
  assign frame       = frame_q;
  assign accessed    = acc_q;
  assign dirty       = dirty_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_wr_en,
  input  logic [ADDR_W-1:0]      base_wr_data,
  input  logic                   miss_valid,
  input  logic [VPN_W-1:0]       miss_vpn,
  output logic                   busy,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_gnt,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   xlat_valid,
  output logic [PTE_FRAME_W-1:0] xlat_frame,
  output logic                   xlat_accessed,
  output logic                   xlat_dirty,
  output logic                   fault_valid,
  output logic [VPN_W-1:0]       walk_vpn
);

  logic [ADDR_W-1:0] base_q;
  logic              load_walk;
  logic              capture_rsp;
  logic              done;

  pgwalk_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base_q  (base_q)
  );

  pgwalk_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .mem_gnt       (mem_gnt),
    .mem_rsp_valid (mem_rsp_valid),
    .load_walk     (load_walk),
    .capture_rsp   (capture_rsp),
    .busy          (busy),
    .mem_req       (mem_req),
    .done          (done)
  );

  pgwalk_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) addr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_walk),
    .base   (base_q),
    .vpn    (miss_vpn),
    .addr_q (mem_addr),
    .vpn_q  (walk_vpn)
  );

  pgwalk_pte_decode dec_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture_rsp),
    .rsp_data    (mem_rsp_data),
    .done        (done),
    .xlat_valid  (xlat_valid),
    .fault_valid (fault_valid),
    .frame       (xlat_frame),
    .accessed    (xlat_accessed),
    .dirty       (xlat_dirty)
  );

endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              mem_rsp_valid,
  input logic              xlat_valid,
  input logic              fault_valid
);

  logic outcome;
  assign outcome = xlat_valid | fault_valid;

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !outcome));

  a_r2_miss_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && miss_valid) |=> (busy && mem_req));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  a_r3_req_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req);

  a_r4_rsp_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req && mem_rsp_valid && !outcome) |=> outcome);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |=> !outcome);

  a_r7_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |=> !busy);

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlat_valid && fault_valid));

endmodule

bind pgwalk_top pgwalk_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_gnt       (mem_gnt),
  .mem_rsp_valid (mem_rsp_valid),
  .xlat_valid    (xlat_valid),
  .fault_valid   (fault_valid)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

  localparam int ADDR_W = 32;
  localparam int VPN_W  = 20;

  logic              clk;
  logic              rst_n;
  logic              base_wr_en;
  logic [ADDR_W-1:0] base_wr_data;
  logic              miss_valid;
  logic [VPN_W-1:0]  miss_vpn;
  logic              busy;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_gnt;
  logic              mem_rsp_valid;
  logic [31:0]       mem_rsp_data;
  logic              xlat_valid;
  logic [19:0]       xlat_frame;
  logic              xlat_accessed;
  logic              xlat_dirty;
  logic              fault_valid;
  logic [VPN_W-1:0]  walk_vpn;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] base_model;

  pgwalk_top #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xlat_valid(xlat_valid), .xlat_frame(xlat_frame),
    .xlat_accessed(xlat_accessed), .xlat_dirty(xlat_dirty),
    .fault_valid(fault_valid), .walk_vpn(walk_vpn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // base write while idle
  task automatic set_base(input logic [ADDR_W-1:0] b);
    @(negedge clk);
    base_wr_en   = 1'b1;
    base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_model = b;
  endtask

  // one full walk; gd/rd = grant/response delay in cycles
  task automatic walk(input logic [VPN_W-1:0] vpn, input logic [31:0] pte,
                      input int gd, input int rd,
                      input bit poke_base, input logic [ADDR_W-1:0] new_base,
                      input bit second_miss);
    logic [ADDR_W-1:0] exp_addr;
    exp_addr = base_model + ADDR_W'({vpn, 2'b00});
    @(negedge clk);
    miss_valid = 1'b1;
    miss_vpn   = vpn;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", 64'(busy), 64'd1);
    chk(mem_req == 1'b1, "R2", "request raised", 64'(mem_req), 64'd1);
    chk(mem_addr == exp_addr, "R2", "entry address", 64'(mem_addr), 64'(exp_addr));
    if (poke_base) begin
      base_wr_en   = 1'b1;
      base_wr_data = new_base;
    end
    for (int i = 0; i < gd; i++) begin
      @(negedge clk);
      base_wr_en = 1'b0;
      chk(mem_req == 1'b1, "R3", "request held", 64'(mem_req), 64'd1);
      chk(mem_addr == exp_addr, poke_base ? "R8" : "R3", "address held",
          64'(mem_addr), 64'(exp_addr));
    end
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt    = 1'b0;
    base_wr_en = 1'b0;
    chk(mem_req == 1'b0, "R3", "request dropped after grant", 64'(mem_req), 64'd0);
    if (second_miss) begin
      miss_valid = 1'b1;
      miss_vpn   = ~vpn;
    end
    for (int i = 0; i < rd; i++) begin
      @(negedge clk);
      chk(!xlat_valid && !fault_valid, "R4", "no result before data",
          64'({xlat_valid, fault_valid}), 64'd0);
      chk(busy == 1'b1, "R7", "busy while waiting", 64'(busy), 64'd1);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    miss_valid    = 1'b0;
    chk(xlat_valid == pte[0], "R5", "xlat_valid", 64'(xlat_valid), 64'(pte[0]));
    chk(fault_valid == !pte[0], "R6", "fault_valid", 64'(fault_valid), 64'(!pte[0]));
    chk(!(xlat_valid && fault_valid), "R9", "exclusive outcome",
        64'({xlat_valid, fault_valid}), 64'd0);
    chk(walk_vpn == vpn, second_miss ? "R7" : "R5", "walk vpn", 64'(walk_vpn), 64'(vpn));
    if (pte[0]) begin
      chk(xlat_frame == pte[31:12], "R5", "frame", 64'(xlat_frame), 64'(pte[31:12]));
      chk(xlat_accessed == pte[1], "R5", "accessed", 64'(xlat_accessed), 64'(pte[1]));
      chk(xlat_dirty == pte[2], "R5", "dirty", 64'(xlat_dirty), 64'(pte[2]));
    end
    @(negedge clk);
    chk(busy == 1'b0, "R7", "busy cleared", 64'(busy), 64'd0);
    chk(!xlat_valid && !fault_valid, "R4", "single-cycle result",
        64'({xlat_valid, fault_valid}), 64'd0);
    chk(mem_req == 1'b0, second_miss ? "R7" : "R1", "no new request",
        64'(mem_req), 64'd0);
    if (poke_base) base_model = new_base;
  endtask

  initial begin
    rst_n = 1'b0;
    base_wr_en = 1'b0; base_wr_data = '0;
    miss_valid = 1'b0; miss_vpn = '0;
    mem_gnt = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    base_model = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !xlat_valid && !fault_valid, "R1", "reset outputs",
        64'({busy, mem_req, xlat_valid, fault_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after release", 64'({busy, mem_req}), 64'd0);

    // attribute x grant delay x response delay sweep
    set_base(32'h0004_0000);
    for (int a = 0; a < 8; a++)
      for (int g = 0; g < 3; g++)
        for (int r = 0; r < 3; r++) begin
          logic [VPN_W-1:0] v;
          logic [19:0] f;
          v = VPN_W'(a * 9 + g * 3 + r);
          f = 20'hA5A5A ^ 20'(v * 37);
          walk(v, {f, 9'h0, 3'(a)}, g, r, 1'b0, '0, 1'b0);
        end

    // base / page-number sweep incl. address wrap and largest page
    for (int b = 0; b < 3; b++) begin
      logic [ADDR_W-1:0] bv;
      bv = (b == 0) ? 32'h0 : (b == 1) ? 32'h0010_0000 : 32'hFFFF_FFF0;
      set_base(bv);
      for (int k = 0; k < 10; k++) begin
        logic [VPN_W-1:0] v;
        v = (k == 8) ? 20'hFFFFF : (k == 9) ? 20'h80000 : VPN_W'(k);
        walk(v, {20'(v) ^ 20'hFFFFF, 9'h1FF, 3'(k)}, k % 2, 1, 1'b0, '0, 1'b0);
      end
    end

    // base rewritten while the request waits for its grant
    set_base(32'h0000_8000);
    walk(20'h00123, 32'h5555_5007, 2, 1, 1'b1, 32'h0020_0000, 1'b0);
    walk(20'h00123, 32'h5555_5000, 0, 0, 1'b0, '0, 1'b0);
    walk(20'h00456, 32'hABCD_E003, 0, 2, 1'b1, 32'h0030_0000, 1'b0);
    walk(20'h00001, 32'h0000_1001, 1, 0, 1'b0, '0, 1'b0);

    // second miss raised while busy must be dropped
    walk(20'h0ABCD, 32'h1234_5001, 1, 2, 1'b0, '0, 1'b1);
    walk(20'h0F00F, 32'h0000_0FFE, 0, 1, 1'b0, '0, 1'b1);

    finish_run();
  end

endmodule